// File: doc/BRIEF.md
# Single-Bit Set, Clear and Branch Unit

This execute unit handles the bit-level instructions of a small 8-bit core. An instruction names one bit of a byte operand with a 3-bit index. That operand is either the accumulator or a zero-page memory byte. The unit can do one of two things with the named bit. It can force the bit to 1 or to 0 and return the edited byte with a write enable for the destination. Or it can test the bit and decide whether a conditional branch is taken, then produce the next program counter.

The sequential program counter is the current PC plus the instruction length. The accumulator form is 2 bytes long and the zero-page form is 3 bytes long. A taken branch adds a sign-extended 8-bit displacement to that advanced PC. The operand byte and the displacement are fetched elsewhere and arrive with the request. Results are registered and appear one clock after the request.

Top module: `bitop_unit`

## Requirements
- R1: Operation code 2'b00 (set) returns `data_o` equal to the operand with bit `bit_idx_i` forced to 1 and every other bit unchanged.
- R2: Operation code 2'b01 (clear) returns `data_o` equal to the operand with bit `bit_idx_i` forced to 0 and every other bit unchanged.
- R3: For set and clear, `mem_src_i`=0 (accumulator) raises only `wr_acc_o`, and `mem_src_i`=1 (zero-page byte) raises only `wr_mem_o`. The two enables are never high together.
- R4: Operation code 2'b10 (branch if bit set) raises `taken_o` exactly when the selected operand bit is 1.
- R5: Operation code 2'b11 (branch if bit clear) raises `taken_o` exactly when the selected operand bit is 0.
- R6: On a taken branch, `next_pc_o` = `pc_i` + length + sign-extended `disp_i`, modulo 2^16. Both the forward and backward directions wrap.
- R7: On a branch that is not taken, and on set or clear, `next_pc_o` = `pc_i` + length. The length is 2 when `mem_src_i`=0 and 3 when `mem_src_i`=1.
- R8: Branch operations raise neither write enable and return `data_o` equal to the unmodified operand.
- R9: A request with `vld_i` high at a rising edge produces its results after that edge. `vld_o` is high for exactly that one cycle.
- R10: With `vld_i` low at an edge, after the edge `vld_o`, `taken_o` and both write enables are low, and `data_o` and `next_pc_o` keep their previous values.
- R11: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Request valid |
| op_i | input | 2 | 00 set, 01 clear, 10 branch if set, 11 branch if clear |
| mem_src_i | input | 1 | 0 accumulator form, 1 zero-page form |
| bit_idx_i | input | 3 | Selected bit position |
| operand_i | input | 8 | Operand byte |
| pc_i | input | 16 | Address of the instruction |
| disp_i | input | 8 | Signed branch displacement |
| vld_o | output | 1 | Result valid |
| data_o | output | 8 | Edited byte, or the operand for branches |
| wr_acc_o | output | 1 | Write enable toward the accumulator |
| wr_mem_o | output | 1 | Write enable toward the memory byte |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 16 | Next program counter |

## Verification
Set and clear are applied to operands where the target bit already holds the forced value and to operands where it flips. This shows whether the edit is a true force or a toggle, and whether neighbouring bits leak into the result. Both branch polarities are tried with the tested bit at 0 and at 1, in both instruction forms. This tells the two polarities apart and catches a length mix-up. Displacements of +127, -128, -16 and 0 near the top and bottom of the address space show whether sign extension happens and whether the sum wraps at 16 bits. Idle cycles after a burst show that the enables drop and that the data and PC outputs hold.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [1:0] {
        BOP_SET   = 2'b00,
        BOP_CLR   = 2'b01,
        BOP_BRSET = 2'b10,
        BOP_BRCLR = 2'b11
    } bop_e;

    function automatic logic bop_is_branch(input bop_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/bitsel_decode.sv
module bitsel_decode #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] operand_i,
    output logic [DATA_W-1:0] mask_o,
    output logic              bit_o
);
    // one-hot mask, one comparator per bit position
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask_o[g] = (idx_i == IDX_W'(g));
    end

    assign bit_o = |(operand_i & mask_o);
endmodule

// File: rtl/bit_editor.sv
module bit_editor #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic              set_i,
    output logic [DATA_W-1:0] data_o
);
    // per-bit mux: selected bit takes set_i, others pass through
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign data_o[g] = mask_i[g] ? set_i : operand_i[g];
    end
endmodule

// File: rtl/pc_target.sv
module pc_target #(
    parameter int PC_W    = 16,
    parameter int DISP_W  = 8,
    parameter int ACC_LEN = 2,
    parameter int MEM_LEN = 3
) (
    input  logic [PC_W-1:0]   pc_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              mem_src_i,
    input  logic              take_i,
    output logic [PC_W-1:0]   next_pc_o
);
    localparam logic [PC_W-1:0] LEN_ACC = PC_W'(ACC_LEN);
    localparam logic [PC_W-1:0] LEN_MEM = PC_W'(MEM_LEN);

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] disp_ext;

    always_comb begin
        seq_pc    = pc_i + (mem_src_i ? LEN_MEM : LEN_ACC);
        disp_ext  = {{(PC_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
        next_pc_o = take_i ? (seq_pc + disp_ext) : seq_pc;
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int PC_W    = 16,
    parameter int DISP_W  = 8,
    parameter int ACC_LEN = 2,
    parameter int MEM_LEN = 3,
    localparam int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [1:0]        op_i,
    input  logic              mem_src_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic              vld_o,
    output logic [DATA_W-1:0] data_o,
    output logic              wr_acc_o,
    output logic              wr_mem_o,
    output logic              taken_o,
    output logic [PC_W-1:0]   next_pc_o
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              wr_acc;
        logic              wr_mem;
        logic              taken;
        logic [PC_W-1:0]   pc;
    } res_t;

    res_t res_d, res_q;

    bop_e              op;
    logic [DATA_W-1:0] mask;
    logic              sel_bit;
    logic [DATA_W-1:0] edited;
    logic              take;
    logic [PC_W-1:0]   tgt_pc;

    assign op = bop_e'(op_i);

    bitsel_decode #(.DATA_W(DATA_W)) u_dec (
        .idx_i     (bit_idx_i),
        .operand_i (operand_i),
        .mask_o    (mask),
        .bit_o     (sel_bit)
    );

    bit_editor #(.DATA_W(DATA_W)) u_edit (
        .operand_i (operand_i),
        .mask_i    (mask),
        .set_i     (op == BOP_SET),
        .data_o    (edited)
    );

    always_comb begin
        unique case (op)
            BOP_BRSET: take = sel_bit;
            BOP_BRCLR: take = ~sel_bit;
            default:   take = 1'b0;
        endcase
    end

    pc_target #(
        .PC_W(PC_W), .DISP_W(DISP_W), .ACC_LEN(ACC_LEN), .MEM_LEN(MEM_LEN)
    ) u_pc (
        .pc_i      (pc_i),
        .disp_i    (disp_i),
        .mem_src_i (mem_src_i),
        .take_i    (take),
        .next_pc_o (tgt_pc)
    );

    always_comb begin
        res_d        = res_q;
        res_d.vld    = 1'b0;
        res_d.wr_acc = 1'b0;
        res_d.wr_mem = 1'b0;
        res_d.taken  = 1'b0;
        if (vld_i) begin
            res_d.vld = 1'b1;
            res_d.pc  = tgt_pc;
            if (bop_is_branch(op)) begin
                res_d.data  = operand_i;
                res_d.taken = take;
            end else begin
                res_d.data   = edited;
                res_d.wr_acc = ~mem_src_i;
                res_d.wr_mem = mem_src_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign vld_o     = res_q.vld;
    assign data_o    = res_q.data;
    assign wr_acc_o  = res_q.wr_acc;
    assign wr_mem_o  = res_q.wr_mem;
    assign taken_o   = res_q.taken;
    assign next_pc_o = res_q.pc;

    AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_acc_o, wr_mem_o})); // R3

    AST_EDIT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !op_i[1]) |=> ($countones(data_o ^ $past(operand_i)) <= 1)); // R1

    AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && op_i[1]) |=> (!wr_acc_o && !wr_mem_o && data_o == $past(operand_i))); // R8

    AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !op_i[1]) |=> (next_pc_o == $past(pc_i) + (PC_W'($past(mem_src_i) ? MEM_LEN : ACC_LEN)))); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> (!vld_o && !taken_o && !wr_acc_o && !wr_mem_o)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> ($stable(next_pc_o) && $stable(data_o))); // R10

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o); // R9
endmodule

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_i = 1'b0;
    logic [1:0]  op_i = '0;
    logic        mem_src_i = 1'b0;
    logic [2:0]  bit_idx_i = '0;
    logic [7:0]  operand_i = '0;
    logic [15:0] pc_i = '0;
    logic [7:0]  disp_i = '0;
    logic        vld_o, wr_acc_o, wr_mem_o, taken_o;
    logic [7:0]  data_o;
    logic [15:0] next_pc_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bitop_unit dut (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .op_i(op_i),
        .mem_src_i(mem_src_i), .bit_idx_i(bit_idx_i), .operand_i(operand_i),
        .pc_i(pc_i), .disp_i(disp_i), .vld_o(vld_o), .data_o(data_o),
        .wr_acc_o(wr_acc_o), .wr_mem_o(wr_mem_o), .taken_o(taken_o),
        .next_pc_o(next_pc_o)
    );

    // {op, src, idx, operand, pc, disp, exp_data, exp_taken, exp_pc}
    localparam int NV = 12;
    localparam logic [62:0] VEC [NV] = '{
        {2'b00, 1'b0, 3'd3, 8'h00, 16'h1000, 8'h10, 8'h08, 1'b0, 16'h1002}, // R1 acc
        {2'b00, 1'b1, 3'd7, 8'h7F, 16'h2000, 8'h00, 8'hFF, 1'b0, 16'h2003}, // R1 mem
        {2'b00, 1'b1, 3'd0, 8'h01, 16'h3000, 8'h00, 8'h01, 1'b0, 16'h3003}, // R1 already set
        {2'b01, 1'b0, 3'd0, 8'hFF, 16'h4000, 8'h00, 8'hFE, 1'b0, 16'h4002}, // R2 acc
        {2'b01, 1'b1, 3'd5, 8'h20, 16'h4010, 8'h00, 8'h00, 1'b0, 16'h4013}, // R2 mem
        {2'b10, 1'b0, 3'd2, 8'h04, 16'h1000, 8'h10, 8'h04, 1'b1, 16'h1012}, // R4 taken
        {2'b10, 1'b1, 3'd6, 8'hBF, 16'h5000, 8'h20, 8'hBF, 1'b0, 16'h5003}, // R4 not taken
        {2'b11, 1'b1, 3'd1, 8'hFD, 16'h6000, 8'h80, 8'hFD, 1'b1, 16'h5F83}, // R5 -128
        {2'b11, 1'b0, 3'd7, 8'h80, 16'h7000, 8'h7F, 8'h80, 1'b0, 16'h7002}, // R5 not taken
        {2'b10, 1'b1, 3'd4, 8'h10, 16'hFFF0, 8'h7F, 8'h10, 1'b1, 16'h0072}, // R6 wrap up
        {2'b11, 1'b0, 3'd3, 8'h00, 16'h0005, 8'hF0, 8'h00, 1'b1, 16'hFFF7}, // R6 wrap down
        {2'b10, 1'b0, 3'd7, 8'h80, 16'hFFFE, 8'h00, 8'h80, 1'b1, 16'h0000}  // R6 zero disp
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 vld", 32'(vld_o), 0);
        chk("R11 data", 32'(data_o), 0);
        chk("R11 wr", 32'({wr_acc_o, wr_mem_o}), 0);
        chk("R11 taken", 32'(taken_o), 0);
        chk("R11 pc", 32'(next_pc_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [62:0] v;
            logic is_br;
            v = VEC[i];
            op_i      = v[62:61];
            mem_src_i = v[60];
            bit_idx_i = v[59:57];
            operand_i = v[56:49];
            pc_i      = v[48:33];
            disp_i    = v[32:25];
            vld_i     = 1'b1;
            is_br     = v[62];
            @(negedge clk);
            chk("R9 vld", 32'(vld_o), 1);
            chk(is_br ? "R8 data" : (v[61] ? "R2 data" : "R1 data"), 32'(data_o), 32'(v[24:17]));
            chk(v[61] ? "R5 taken" : "R4 taken", 32'(taken_o), 32'(v[16]));
            chk(v[16] ? "R6 pc" : "R7 pc", 32'(next_pc_o), 32'(v[15:0]));
            chk(is_br ? "R8 wr" : "R3 wr", 32'({wr_acc_o, wr_mem_o}),
                is_br ? 0 : (mem_src_i ? 32'd1 : 32'd2));
        end

        // R10 / R9: idle after last vector, outputs hold
        vld_i = 1'b0;
        operand_i = 8'h55;
        pc_i = 16'h1234;
        @(negedge clk);
        chk("R9 vld drop", 32'(vld_o), 0);
        chk("R10 taken", 32'(taken_o), 0);
        chk("R10 wr", 32'({wr_acc_o, wr_mem_o}), 0);
        chk("R10 data hold", 32'(data_o), 32'h80);
        chk("R10 pc hold", 32'(next_pc_o), 32'h0000);

        // R3: back-to-back edits switch destination
        vld_i = 1'b1; op_i = 2'b01; mem_src_i = 1'b1; bit_idx_i = 3'd6;
        operand_i = 8'hFF; pc_i = 16'h0100;
        @(negedge clk);
        chk("R3 mem", 32'({wr_acc_o, wr_mem_o}), 32'd1);
        chk("R2 bit6", 32'(data_o), 32'hBF);
        mem_src_i = 1'b0;
        @(negedge clk);
        chk("R3 acc", 32'({wr_acc_o, wr_mem_o}), 32'd2);
        chk("R7 acc len", 32'(next_pc_o), 32'h0102);
        vld_i = 1'b0;
        @(negedge clk);

        // R11: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 rst data", 32'(data_o), 0);
        chk("R11 rst pc", 32'(next_pc_o), 0);

        done = 1'b1;
        finish_run();
    end
endmodule